// File: doc/BRIEF.md
# Warp Divergence Lane-Mask Stack

This block tracks which lanes of one warp are live while the warp runs through data-dependent branches. Each lane keeps its own state, so lanes can disagree on a branch. When they disagree, the block runs the two sides one after the other. First the lanes that took the branch run, with the others masked off. Then the lanes that did not take it run, with the first group masked off. After that, the mask the warp had before the branch comes back. Before a split, a small stack saves the pre-branch mask and the mask of the deferred side. Nested branches therefore compound: each inner split further narrows whatever mask is current.

A masked lane still occupies its slot and its issue cycle, but its write-enable is held low, so its result is thrown away. The sequencer around the block reports a branch event together with a per-lane taken vector. It pulses a pop when the current path ends, and that pop serves as both the else marker and the reconvergence marker. The block returns four things: the live mask, a per-lane write-enable, a symbolic code for the kind of path now running, and a flag that is high while the warp runs a masked subset. A sticky error flag records a stack overflow, a pop with nothing to pop, or a branch and a pop requested in the same cycle.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset, mask_o is all ones, path_o is 0 (base path), depth_o is 0, diverged_o is 0 and err_o is 0.
- R2: A branch that splits the active lanes (taken_i & mask_o is neither zero nor equal to mask_o) sets mask_o to mask_o & taken_i and path_o to 1 (taken path), and raises depth_o by 2 on the next cycle.
- R3: A splitting branch that finds depth_o + 2 greater than DEPTH sets err_o and leaves mask_o, path_o and depth_o unchanged.
- R4: A branch where all active lanes agree (taken_i & mask_o equal to zero or to mask_o) changes nothing. Lanes already masked off are not counted.
- R5: The first pop after a split sets mask_o to the pre-branch mask with the taken lanes cleared, sets path_o to 2 (else path), and lowers depth_o by 1.
- R6: The second pop after a split restores the pre-branch mask and the path_o code that was current before the branch, and lowers depth_o by 1 again.
- R7: A split inside a taken or else path narrows the current mask, and its two sides finish before the enclosing deferred side runs.
- R8: diverged_o is 1 exactly when depth_o is nonzero.
- R9: lane_we_o equals mask_o while issue_i is 1, and is all zeros while issue_i is 0.
- R10: A pop with depth_o equal to 0 sets err_o and changes no mask or path state.
- R11: A branch and a pop in the same cycle set err_o, and neither one takes effect.
- R12: Once set, err_o stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| branch_i | input | 1 | Branch event this cycle |
| taken_i | input | LANES | Per-lane branch direction, 1 = taken |
| pop_i | input | 1 | End of current path (else or reconvergence marker) |
| issue_i | input | 1 | An instruction issues this cycle |
| mask_o | output | LANES | Current active-lane mask |
| lane_we_o | output | LANES | Per-lane write-enable for the issuing instruction |
| path_o | output | 2 | Path kind: 0 base, 1 taken, 2 else |
| depth_o | output | $clog2(DEPTH+1) | Entries on the stack |
| diverged_o | output | 1 | Warp runs a masked subset |
| err_o | output | 1 | Sticky overflow, underflow or conflict flag |

## Verification
The branch evaluation and the path-end pop can be requested in the same cycle. The bench forces this case by raising branch_i and pop_i together while the warp sits inside a split path. It then judges the outcome on the next cycle: the mask, path code and depth must match what they were before that cycle, and err_o must be high. A second clash is a split branch on a full stack. In that case the overflow must be flagged while the existing stack is left as it was.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic [1:0] {
    PATH_BASE  = 2'd0,
    PATH_TAKEN = 2'd1,
    PATH_ELSE  = 2'd2
  } path_e;
endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] active_i,
  input  logic [LANES-1:0] taken_i,
  output logic             split_o,
  output logic [LANES-1:0] taken_mask_o,
  output logic [LANES-1:0] else_mask_o
);
  always_comb begin
    taken_mask_o = active_i & taken_i;
    else_mask_o  = active_i & ~taken_i;
    // divergent only if both sides keep at least one lane
    split_o      = (|taken_mask_o) && (|else_mask_o);
  end
endmodule

// File: rtl/simt_stack_mem.sv
module simt_stack_mem
  import simt_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int DEPTH   = 8,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push2_i,
  input  logic               pop_i,
  input  logic [LANES-1:0]   join_mask_i,
  input  path_e              join_path_i,
  input  logic [LANES-1:0]   else_mask_i,
  output logic [LANES-1:0]   top_mask_o,
  output path_e              top_path_o,
  output logic [DEPTH_W-1:0] depth_o
);
  logic [LANES-1:0]   mask_q [DEPTH];
  path_e              path_q [DEPTH];
  logic [DEPTH_W-1:0] depth_q;
  logic [DEPTH_W-1:0] top_idx;

  assign top_idx = depth_q - DEPTH_W'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[g] <= '0;
        path_q[g] <= PATH_BASE;
      end else if (push2_i) begin
        if (depth_q == DEPTH_W'(g)) begin
          mask_q[g] <= join_mask_i;
          path_q[g] <= join_path_i;
        end else if (depth_q + DEPTH_W'(1) == DEPTH_W'(g)) begin
          mask_q[g] <= else_mask_i;
          path_q[g] <= PATH_ELSE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      depth_q <= '0;
    else if (push2_i) depth_q <= depth_q + DEPTH_W'(2);
    else if (pop_i)   depth_q <= depth_q - DEPTH_W'(1);
  end

  always_comb begin
    top_mask_o = '0;
    top_path_o = PATH_BASE;
    for (int i = 0; i < DEPTH; i++) begin
      if (top_idx == DEPTH_W'(i)) begin
        top_mask_o = mask_q[i];
        top_path_o = path_q[i];
      end
    end
  end

  assign depth_o = depth_q;
endmodule

// File: rtl/simt_lane_gate.sv
module simt_lane_gate #(
  parameter int LANES = 32
) (
  input  logic             issue_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] we_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign we_o[l] = issue_i & mask_i[l];
  end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int DEPTH   = 8,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               branch_i,
  input  logic [LANES-1:0]   taken_i,
  input  logic               pop_i,
  input  logic               issue_i,
  output logic [LANES-1:0]   mask_o,
  output logic [LANES-1:0]   lane_we_o,
  output logic [1:0]         path_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               diverged_o,
  output logic               err_o
);
  logic [LANES-1:0] mask_q;
  path_e            path_q;
  logic             err_q;

  logic             split;
  logic [LANES-1:0] taken_mask, else_mask;
  logic [LANES-1:0] top_mask;
  path_e            top_path;
  logic [DEPTH_W-1:0] depth;

  logic room, do_split, do_pop, ovf, under, conflict;

  simt_branch_eval #(.LANES(LANES)) i_eval (
    .active_i     (mask_q),
    .taken_i      (taken_i),
    .split_o      (split),
    .taken_mask_o (taken_mask),
    .else_mask_o  (else_mask)
  );

  simt_stack_mem #(.LANES(LANES), .DEPTH(DEPTH)) i_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push2_i     (do_split),
    .pop_i       (do_pop),
    .join_mask_i (mask_q),
    .join_path_i (path_q),
    .else_mask_i (else_mask),
    .top_mask_o  (top_mask),
    .top_path_o  (top_path),
    .depth_o     (depth)
  );

  simt_lane_gate #(.LANES(LANES)) i_gate (
    .issue_i (issue_i),
    .mask_i  (mask_q),
    .we_o    (lane_we_o)
  );

  always_comb begin
    room     = (int'(depth) + 2) <= DEPTH;
    conflict = branch_i & pop_i;
    do_split = branch_i & ~pop_i & split & room;
    ovf      = branch_i & ~pop_i & split & ~room;
    do_pop   = pop_i & ~branch_i & (depth != '0);
    under    = pop_i & ~branch_i & (depth == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      path_q <= PATH_BASE;
      err_q  <= 1'b0;
    end else begin
      if (conflict || ovf || under) err_q <= 1'b1;
      if (do_split) begin
        mask_q <= taken_mask;
        path_q <= PATH_TAKEN;
      end else if (do_pop) begin
        mask_q <= top_mask;
        path_q <= top_path;
      end
    end
  end

  assign mask_o     = mask_q;
  assign path_o     = path_q;
  assign depth_o    = depth;
  assign diverged_o = (depth != '0);
  assign err_o      = err_q;
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
  parameter int LANES   = 32,
  parameter int DEPTH   = 8,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               branch_i,
  input logic [LANES-1:0]   taken_i,
  input logic               pop_i,
  input logic               issue_i,
  input logic [LANES-1:0]   mask_o,
  input logic [LANES-1:0]   lane_we_o,
  input logic [1:0]         path_o,
  input logic [DEPTH_W-1:0] depth_o,
  input logic               diverged_o,
  input logic               err_o
);
  logic uniform;
  assign uniform = ((taken_i & mask_o) == '0) || ((taken_i & mask_o) == mask_o);

  p_split_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_i && !pop_i && !uniform && (int'(depth_o) + 2 <= DEPTH)
    |=> mask_o == $past(mask_o & taken_i) && path_o == 2'd1);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(depth_o) <= DEPTH);

  p_uniform_still_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_i && !pop_i && uniform |=> $stable(mask_o) && $stable(depth_o));

  p_div_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diverged_o == (depth_o != '0));

  p_we_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_we_o & ~mask_o) == '0 && (issue_i || lane_we_o == '0));

  p_pop_depth_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !branch_i && depth_o != '0 |=> depth_o == $past(depth_o) - DEPTH_W'(1));

  p_conflict_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_i && pop_i |=> err_o && $stable(mask_o) && $stable(depth_o));

  p_err_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES), .DEPTH(DEPTH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .branch_i   (branch_i),
  .taken_i    (taken_i),
  .pop_i      (pop_i),
  .issue_i    (issue_i),
  .mask_o     (mask_o),
  .lane_we_o  (lane_we_o),
  .path_o     (path_o),
  .depth_o    (depth_o),
  .diverged_o (diverged_o),
  .err_o      (err_o)
);

// File: tb/test_simt_mask_stack.sv
module test_simt_mask_stack;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int DEPTH = 8;
  localparam int DW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic branch_i = 1'b0, pop_i = 1'b0, issue_i = 1'b0;
  logic [LANES-1:0] taken_i = '0;
  logic [LANES-1:0] mask_o, lane_we_o;
  logic [1:0] path_o;
  logic [DW-1:0] depth_o;
  logic diverged_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) i_simt_mask_stack (
    .clk_i(clk), .rst_ni(rst_ni), .branch_i(branch_i), .taken_i(taken_i),
    .pop_i(pop_i), .issue_i(issue_i), .mask_o(mask_o), .lane_we_o(lane_we_o),
    .path_o(path_o), .depth_o(depth_o), .diverged_o(diverged_o), .err_o(err_o)
  );

  typedef struct {
    logic [LANES-1:0] mask;
    logic [1:0]       path;
    int               depth;
    logic             err;
    string            tag;
  } exp_t;

  exp_t q[$];

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (mask_o !== e.mask || path_o !== e.path || int'(depth_o) != e.depth ||
          err_o !== e.err || diverged_o !== (e.depth != 0)) begin
        errors++;
        $display("FAIL %s: mask=%h path=%0d depth=%0d div=%0b err=%0b expected mask=%h path=%0d depth=%0d div=%0b err=%0b",
                 e.tag, mask_o, path_o, depth_o, diverged_o, err_o,
                 e.mask, e.path, e.depth, (e.depth != 0), e.err);
      end
    end
  end

  task automatic expect_now(logic [LANES-1:0] m, logic [1:0] p, int d, logic er, string tag);
    exp_t e;
    e.mask = m; e.path = p; e.depth = d; e.err = er; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(bit br, bit pp, logic [LANES-1:0] tk,
                      logic [LANES-1:0] m, logic [1:0] p, int d, logic er, string tag);
    branch_i = br; pop_i = pp; taken_i = tk;
    @(posedge clk); #1;
    expect_now(m, p, d, er, tag);
    @(negedge clk);
    branch_i = 0; pop_i = 0; taken_i = '0;
  endtask

  task automatic check_we(bit iss, logic [LANES-1:0] exp_we, string tag);
    issue_i = iss;
    #1;
    checks++;
    if (lane_we_o !== exp_we) begin
      errors++;
      $display("FAIL %s: lane_we=%h expected %h", tag, lane_we_o, exp_we);
    end
    issue_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(posedge clk); #1;
    expect_now('1, 2'd0, 0, 0, "R1 reset state");
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    check_we(1, 32'hFFFF_FFFF, "R9 full warp write-enable");
    // R4: uniform decisions
    step(1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 0, 0, "R4 all taken");
    step(1, 0, 32'h0000_0000, 32'hFFFF_FFFF, 2'd0, 0, 0, "R4 none taken");
    // R2 / R7: nested split
    step(1, 0, 32'h0000_FFFF, 32'h0000_FFFF, 2'd1, 2, 0, "R2 outer split");
    step(1, 0, 32'hF0F0_00FF, 32'h0000_00FF, 2'd1, 4, 0, "R7 inner split uses active lanes");
    check_we(1, 32'h0000_00FF, "R9 masked lanes suppressed");
    check_we(0, 32'h0000_0000, "R9 no issue");
    step(0, 1, '0, 32'h0000_FF00, 2'd2, 3, 0, "R5 inner else");
    step(0, 1, '0, 32'h0000_FFFF, 2'd1, 2, 0, "R6 inner rejoin to taken path");
    step(0, 1, '0, 32'hFFFF_0000, 2'd2, 1, 0, "R5 outer else");
    step(0, 1, '0, 32'hFFFF_FFFF, 2'd0, 0, 0, "R6 outer rejoin");
    // bounds guard: lanes 0..19 pass
    step(1, 0, 32'h000F_FFFF, 32'h000F_FFFF, 2'd1, 2, 0, "R2 bounds guard 20 lanes");
    step(1, 0, 32'hFFF0_0000, 32'h000F_FFFF, 2'd1, 2, 0, "R4 inactive lanes ignored");
    step(0, 1, '0, 32'hFFF0_0000, 2'd2, 1, 0, "R5 guard tail");
    // R11: branch and pop together inside else path
    step(1, 1, 32'h0010_0000, 32'hFFF0_0000, 2'd2, 1, 1, "R11 branch+pop conflict");
    step(0, 1, '0, 32'hFFFF_FFFF, 2'd0, 0, 1, "R12 err sticky, R6 rejoin");
    do_reset();
    step(0, 1, '0, 32'hFFFF_FFFF, 2'd0, 0, 1, "R10 pop on empty");
    do_reset();
    // R3: fill stack then overflow
    step(1, 0, 32'h0000_FFFF, 32'h0000_FFFF, 2'd1, 2, 0, "R7 level 1");
    step(1, 0, 32'h0000_00FF, 32'h0000_00FF, 2'd1, 4, 0, "R7 level 2");
    step(1, 0, 32'h0000_000F, 32'h0000_000F, 2'd1, 6, 0, "R7 level 3");
    step(1, 0, 32'h0000_0003, 32'h0000_0003, 2'd1, 8, 0, "R7 level 4 full");
    step(1, 0, 32'h0000_0001, 32'h0000_0003, 2'd1, 8, 1, "R3 overflow");
    step(0, 1, '0, 32'h0000_000C, 2'd2, 7, 1, "R5 after overflow");
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule